// File: doc/BRIEF.md
# Nibble Input Debounce Filter

This block removes glitches and contact bounce from eight digital input channels. The channels are split into two groups of four, called nibbles. Each nibble has its own bypass bit and its own two-bit time selector, and both come from one configuration byte. For each nibble, a free-running prescaler turns the system clock into a sample strobe. A channel's filtered level flips only after the raw input has disagreed with it on a fixed number of consecutive strobes.

The selector picks a sample period of 1, 64, 256 or 512 clocks. With the fixed run length of 14 samples, the settling times are about 14, 896, 3584 and 7168 clocks. When a nibble is bypassed, its outputs copy the raw inputs at once. Its filters keep tracking in the background, so clearing the bypass does not cause a jump back to a stale level. The raw inputs are expected to be synchronous to `clk` already.

Top module: `dig_in_debounce`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every filtered level and every output bit is 0, whatever the state of `pin_in`.
- R2: Configuration byte fields are as follows. Bit 7 bypasses the upper nibble (channels 7..4). Bits 5:4 select the upper nibble's time. Bit 3 bypasses the lower nibble (channels 3..0). Bits 1:0 select the lower nibble's time. Bits 6 and 2 have no effect.
- R3: When a nibble's bypass bit is 1, that nibble's `pin_out` bits equal its `pin_in` bits in the same cycle, with no clock edge between them.
- R4: Time code 00 samples on every clock edge. A channel's output takes a new input level on the 14th consecutive edge that sees that level, and not before.
- R5: A sample that agrees with the current filtered level clears that channel's run count, so a full 14 fresh disagreeing samples are needed afterwards.
- R6: Codes 01, 10 and 11 sample every 64, 256 and 512 clocks. Suppose the input changes together with a switch to one of these codes. The output then flips on edge 896, 3584 or 7168 counted from the edge where the switch is seen.
- R7: On the edge where a nibble's time code differs from the one it last used, the nibble's prescaler restarts and takes no sample, even if a sample was due. The next sample comes one full new period later.
- R8: The two nibbles filter independently. A code or input change in one nibble does not change the timing of the other.
- R9: A bypassed nibble's filters keep sampling. When the bypass is cleared, the output shows the level the filter has already settled to.
- R10: A filtered level changes only on a sample edge. A sample equal to the current level never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_cfg | input | 8 | Configuration byte (bypass and time code per nibble) |
| pin_in | input | 8 | Raw input levels, synchronous to `clk` |
| pin_out | output | 8 | Debounced levels, or raw levels for a bypassed nibble |

## Verification
A time-code change and a sample strobe can fall due on the same edge, and the restart rule decides which one wins. The bench provokes this case directly. It selects the 64-clock code with a changed input, waits exactly 64 edges so that the next edge would carry a strobe, and switches to the 512-clock code on that very edge. The result is judged from the port alone: the output must flip exactly 7168 edges after the switch. If the colliding strobe were taken as a sample, the flip would come 512 edges early.

// File: rtl/dinf_pkg.sv
package dinf_pkg;

    // Width of one nibble's slice in the configuration byte.
    localparam int CFG_SLICE_W = 4;
    // Field positions inside a slice (the neighbour decode depends on them).
    localparam int BYP_POS = 3;
    localparam int SEL_LSB = 0;
    localparam int SPARE_POS = 2;

    typedef logic [1:0] tsel_t;

    typedef struct packed {
        logic  bypass;
        tsel_t tsel;
    } nib_cfg_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dinf_cfg_decode.sv
module dinf_cfg_decode
    import dinf_pkg::*;
#(
    parameter int NUM_NIB = 2
) (
    input  logic [CFG_SLICE_W*NUM_NIB-1:0] cfg_raw,
    output nib_cfg_t [NUM_NIB-1:0]         nib_cfg
);

    logic [NUM_NIB-1:0] spare_bits;
    logic               unused_spare;

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_slice
        always_comb begin
            nib_cfg[g].bypass = cfg_raw[CFG_SLICE_W*g + BYP_POS];
            nib_cfg[g].tsel   = cfg_raw[CFG_SLICE_W*g + SEL_LSB +: 2];
            spare_bits[g]     = cfg_raw[CFG_SLICE_W*g + SPARE_POS];
        end
    end

    // Spare bits carry no function; fold them away.
    assign unused_spare = ^spare_bits;

endmodule

// File: rtl/dinf_prescaler.sv
module dinf_prescaler
    import dinf_pkg::*;
#(
    parameter int DIV_SEL0 = 1,
    parameter int DIV_SEL1 = 64,
    parameter int DIV_SEL2 = 256,
    parameter int DIV_SEL3 = 512
) (
    input  logic  clk,
    input  logic  rst_n,
    input  tsel_t tsel,
    output logic  strobe
);

    localparam int DIV_MAX = max4(DIV_SEL0, DIV_SEL1, DIV_SEL2, DIV_SEL3);
    localparam int PS_W    = $clog2(DIV_MAX + 1);

    typedef struct packed {
        tsel_t           sel;
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t       state_d, state_q;
    logic [PS_W-1:0] last_cnt;

    always_comb begin
        unique case (state_q.sel)
            2'd0:    last_cnt = PS_W'(DIV_SEL0 - 1);
            2'd1:    last_cnt = PS_W'(DIV_SEL1 - 1);
            2'd2:    last_cnt = PS_W'(DIV_SEL2 - 1);
            default: last_cnt = PS_W'(DIV_SEL3 - 1);
        endcase

        state_d = state_q;
        strobe  = 1'b0;
        if (tsel != state_q.sel) begin
            // New period requested: restart, skip this edge.
            state_d.sel = tsel;
            state_d.cnt = '0;
        end else if (state_q.cnt >= last_cnt) begin
            strobe      = 1'b1;
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dinf_channel.sv
module dinf_channel #(
    parameter int SETTLE_SMP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic raw,
    output logic level
);

    localparam int RUN_W = $clog2(SETTLE_SMP + 1);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
    } ch_state_t;

    ch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (strobe) begin
            if (raw == state_q.lvl) begin
                state_d.run = '0;
            end else if (state_q.run == RUN_W'(SETTLE_SMP - 1)) begin
                state_d.lvl = raw;
                state_d.run = '0;
            end else begin
                state_d.run = state_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level = state_q.lvl;

endmodule

// File: rtl/dig_in_debounce.sv
module dig_in_debounce
    import dinf_pkg::*;
#(
    parameter int NUM_NIB    = 2,
    parameter int CH_PER_NIB = 4,
    parameter int SETTLE_SMP = 14,
    parameter int DIV_SEL0   = 1,
    parameter int DIV_SEL1   = 64,
    parameter int DIV_SEL2   = 256,
    parameter int DIV_SEL3   = 512
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CFG_SLICE_W*NUM_NIB-1:0]   filt_cfg,
    input  logic [NUM_NIB*CH_PER_NIB-1:0]    pin_in,
    output logic [NUM_NIB*CH_PER_NIB-1:0]    pin_out
);

    localparam int NUM_CH = NUM_NIB * CH_PER_NIB;

    nib_cfg_t [NUM_NIB-1:0] nib_cfg;
    tsel_t    [NUM_NIB-1:0] grp_sel;
    logic     [NUM_NIB-1:0] grp_byp;
    logic     [NUM_NIB-1:0] smp_stb;
    logic     [NUM_CH-1:0]  flt_lvl;

    dinf_cfg_decode #(
        .NUM_NIB (NUM_NIB)
    ) u_decode (
        .cfg_raw (filt_cfg),
        .nib_cfg (nib_cfg)
    );

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        assign grp_sel[g] = nib_cfg[g].tsel;
        assign grp_byp[g] = nib_cfg[g].bypass;

        dinf_prescaler #(
            .DIV_SEL0 (DIV_SEL0),
            .DIV_SEL1 (DIV_SEL1),
            .DIV_SEL2 (DIV_SEL2),
            .DIV_SEL3 (DIV_SEL3)
        ) u_ps (
            .clk    (clk),
            .rst_n  (rst_n),
            .tsel   (grp_sel[g]),
            .strobe (smp_stb[g])
        );

        for (genvar c = 0; c < CH_PER_NIB; c++) begin : g_ch
            localparam int IDX = g*CH_PER_NIB + c;

            dinf_channel #(
                .SETTLE_SMP (SETTLE_SMP)
            ) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .strobe (smp_stb[g]),
                .raw    (pin_in[IDX]),
                .level  (flt_lvl[IDX])
            );

            assign pin_out[IDX] = grp_byp[g] ? pin_in[IDX] : flt_lvl[IDX];
        end
    end

endmodule

// File: rtl/dig_in_debounce_chk.sv
module dig_in_debounce_chk
    import dinf_pkg::*;
#(
    parameter int NUM_NIB    = 2,
    parameter int CH_PER_NIB = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_NIB*CH_PER_NIB-1:0] pin_in,
    input tsel_t [NUM_NIB-1:0]           grp_sel,
    input logic [NUM_NIB-1:0]            smp_stb,
    input logic [NUM_NIB*CH_PER_NIB-1:0] flt_lvl
);

    // R1
    rst_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flt_lvl == '0));

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        // R4
        code0_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && grp_sel[g] == 2'd0 && $past(grp_sel[g]) == 2'd0)
            |-> smp_stb[g]);

        // R7
        stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_stb[g] && grp_sel[g] != 2'd0) |=> !smp_stb[g]);

        // R7
        restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && grp_sel[g] != $past(grp_sel[g])) |-> !smp_stb[g]);

        for (genvar c = 0; c < CH_PER_NIB; c++) begin : g_ch
            localparam int IDX = g*CH_PER_NIB + c;

            // R10
            lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !smp_stb[g] |=> $stable(flt_lvl[IDX]));

            // R10
            agree_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_stb[g] && pin_in[IDX] == flt_lvl[IDX]) |=> $stable(flt_lvl[IDX]));
        end
    end

endmodule

bind dig_in_debounce dig_in_debounce_chk #(
    .NUM_NIB    (NUM_NIB),
    .CH_PER_NIB (CH_PER_NIB)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .grp_sel (grp_sel),
    .smp_stb (smp_stb),
    .flt_lvl (flt_lvl)
);

// File: tb/dig_in_debounce_test.sv
module dig_in_debounce_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] filt_cfg;
    logic [7:0] pin_in;
    logic [7:0] pin_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dig_in_debounce uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_cfg (filt_cfg),
        .pin_in   (pin_in),
        .pin_out  (pin_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] exp);
        n_chk++;
        if (pin_out !== exp) begin
            n_fail++;
            $display("FAIL %s: pin_out actual %02h expected %02h", tag, pin_out, exp);
        end
    endtask

    // Return all channels to level 0 with code 00 selected.
    task automatic settle_zero();
        filt_cfg = 8'h00;
        pin_in   = 8'h00;
        step(15);
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        filt_cfg = 8'h00;
        pin_in   = 8'hFF;
        step(3);
        chk("R1 during reset", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        chk("R1 first cycle after reset", 8'h00);
        pin_in = 8'h00;
        step(3);
        chk("R1 still zero", 8'h00);
    endtask

    task automatic t_code0();
        pin_in = 8'h01;
        step(13);
        chk("R4 R10 no flip after 13 samples", 8'h00);
        step(1);
        chk("R4 flip on 14th sample", 8'h01);
        pin_in = 8'h00;
        step(14);
        chk("R4 flip back", 8'h00);
    endtask

    task automatic t_agree_clears();
        pin_in = 8'h02;
        step(10);
        pin_in = 8'h00;
        step(1);
        pin_in = 8'h02;
        step(13);
        chk("R5 run restarted", 8'h00);
        step(1);
        chk("R5 flip after fresh 14", 8'h02);
        settle_zero();
        chk("R5 settle", 8'h00);
    endtask

    task automatic t_spare_bits();
        filt_cfg = 8'h44;
        pin_in   = 8'h84;
        step(0);
        chk("R2 spare bits do not bypass", 8'h00);
        step(13);
        chk("R2 spare bits keep timing", 8'h00);
        step(1);
        chk("R2 flip at 14 with spare bits", 8'h84);
        settle_zero();
    endtask

    task automatic t_bypass();
        filt_cfg = 8'h08;
        pin_in   = 8'h15;
        step(0);
        chk("R3 lower bypass immediate, upper filtered", 8'h05);
        step(20);
        chk("R8 upper settled while lower bypassed", 8'h15);
        filt_cfg = 8'h00;
        step(0);
        chk("R9 tracked level after bypass clear", 8'h15);
        filt_cfg = 8'h80;
        pin_in   = 8'h40;
        step(0);
        chk("R3 upper bypass immediate", 8'h45);
        settle_zero();
        chk("R3 settle", 8'h00);
    endtask

    task automatic t_slow(input logic [7:0] cfg, input logic [7:0] pat,
                          input int edges, input string tag);
        filt_cfg = cfg;
        pin_in   = pat;
        step(edges);
        chk({tag, " before flip"}, 8'h00);
        step(1);
        chk({tag, " at flip"}, pat);
        settle_zero();
    endtask

    task automatic t_restart_collide();
        filt_cfg = 8'h01;
        pin_in   = 8'h08;
        step(64);
        chk("R7 no sample yet", 8'h00);
        filt_cfg = 8'h03;
        step(7168);
        chk("R7 collided strobe not taken", 8'h00);
        step(1);
        chk("R7 flip one full new window later", 8'h08);
        settle_zero();
    endtask

    task automatic t_independent();
        filt_cfg = 8'h10;
        pin_in   = 8'h11;
        step(14);
        chk("R8 lower flips at 14", 8'h01);
        step(882);
        chk("R8 upper still old", 8'h01);
        step(1);
        chk("R8 upper flips at 896", 8'h11);
        settle_zero();
        chk("R8 settle", 8'h00);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_code0();
        t_agree_clears();
        t_spare_bits();
        t_bypass();
        t_slow(8'h01, 8'h01, 896, "R6 code 01");
        t_slow(8'h02, 8'h02, 3584, "R6 code 10");
        t_restart_collide();
        t_independent();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule